// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits on the host side of a byte-wide asynchronous static RAM with a 17-bit address (131,072 bytes) and an 8-bit data bus. It takes one read or write command at a time on a request/ready port. It then drives the RAM's active-low chip enable, output enable and write enable, together with the address and write data, so that every access-time, pulse-width, setup and hold limit of the memory is met. Read data is registered and returned with a one-cycle valid pulse.

All memory limits are module parameters in nanoseconds. Each one is turned into a whole number of clock cycles by rounding up against a clock-period parameter. The data bus leaves the block as a separate output, output-enable and input, so that a pad ring or a bench can build the tristate.

A write is framed by two events. It opens when the later of chip enable and write enable goes low, and it closes when the earlier of the two returns high. This controller moves both strobes on the same clock edge, so the window is exactly the span in which both are low. Address and data are presented one cycle before that window and held after it.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset, req_ready is 1, ram_ce_n, ram_oe_n and ram_we_n are 1, ram_dq_oe is 0 and rsp_valid is 0.
- R2: A command is taken only at a clock edge where req_ready is 1 and req_valid is 1 (req_write=1 is a write, 0 a read). req_ready is 0 from that edge until the command is done. A request offered while req_ready is 0 is dropped and changes no memory byte.
- R3: A read holds ram_ce_n=0, ram_oe_n=0 and ram_we_n=1 for RD_CYC cycles. RD_CYC is ceil(max(address access 70 ns, enable access 70 ns, output-enable access 35 ns) / clock period), which is 7 at 10 ns. The bus is sampled at the edge that ends this window. rsp_valid is then 1 for exactly one cycle, starting 7 edges after the accepting edge, with rsp_rdata holding the sampled byte. req_ready returns 8 edges after acceptance.
- R4: In a write, ram_addr and ram_dq_out (with ram_dq_oe=1) are presented one cycle before the strobes fall. ram_ce_n and ram_we_n then fall together and stay low for WP_CYC cycles, where WP_CYC = ceil(max(55 ns pulse, 30 ns data setup) / period), which is 6. ram_we_n is never low while ram_ce_n is high.
- R5: After the strobes rise, ram_addr and the driven data stay unchanged for at least ceil(5 ns / period) cycles, with a minimum of 1. The whole write, from address presentation to release of the bus, lasts at least ceil(70 ns / period) cycles. req_ready returns 8 edges after acceptance at the default values.
- R6: ram_oe_n stays 1 for the whole of a write. ram_dq_oe is never 1 while ram_oe_n is 0.
- R7: A write whose accepted predecessor was a read gets one extra idle cycle before its address and data are presented, so req_ready returns 9 edges after acceptance.
- R8: ram_addr does not change while ram_ce_n is 0.
- R9: A read returns the byte most recently written to the same address, across the full address range including 0x00000 and 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Idle, a command will be taken this cycle |
| rsp_valid | output | 1 | One-cycle pulse: rsp_rdata holds read data |
| rsp_rdata | output | 8 | Registered read byte |
| ram_addr | output | 17 | RAM address |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_dq_out | output | 8 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | 1 = controller drives the data bus |
| ram_dq_in | input | 8 | Data returned from the RAM bus |

## Verification
Some rules are checked on every cycle inside the RTL:
- output enable and the write strobe are never low together, and the controller never drives the bus against an enabled RAM output;
- the write strobe stays inside chip enable;
- the address holds still under chip enable;
- the write pulse and total write length meet their cycle counts, and data and address hold past the rising strobe;
- the read response is a single-cycle pulse.

Other behaviour only the bench scenarios can show. These are the exact acceptance-to-ready latencies, the extra turnaround after a read, dropped requests while busy, and end-to-end data integrity at the extreme addresses. The bench RAM model returns corrupted bytes whenever an access time is cut short, so a read that samples too early shows up as a data mismatch.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and constant helpers for the asynchronous RAM controller.
// Assumes all timing parameters are positive integers in nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // waiting for a command
        ST_TURN = 3'd1,  // bus turnaround between a read and a write
        ST_WSET = 3'd2,  // address and data presented, strobes high
        ST_WPUL = 3'd3,  // chip enable and write enable low
        ST_WREC = 3'd4,  // strobes high, address/data still held
        ST_RACC = 3'd5,  // read access window
        ST_REND = 3'd6   // read strobes released
    } seq_state_t;

    // Round a nanosecond figure up to whole clock cycles.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
// Down-counter used to time strobe phases. A load sets the count to N-1,
// so the phase that loaded it ends after N cycles, when expired is seen.
// Assumes load is only raised on a phase transition.
module sram_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count down to zero, reloading on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R3 R4: once run out and not reloaded, the timer stays run out
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/sram_rd_capture.sv
// Read-data register. Samples the RAM bus on the capture strobe and
// raises a one-cycle valid flag alongside the registered byte.
// Assumes capture is never raised on two consecutive cycles.
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    // Register the sampled byte and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture)
                rsp_rdata <= bus_in;
        end
    end

    // R3: the response is a single-cycle pulse
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_seq_fsm.sv
// Command sequencer. Takes one command in idle and steps through the
// setup, strobe and recovery phases, driving registered RAM strobes.
// Both strobes move on the same edge, so the write window equals the span
// in which both are low. Assumes the timer is loaded only by this module.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 4,
    parameter int RD_CYC   = 7,
    parameter int WP_CYC   = 6,
    parameter int WREC_CYC = 1,
    parameter int WC_CYC   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              capture,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_ce_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe
);

    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WREC_CYC - 1);

    seq_state_t        state_q, state_d;
    logic              accept;
    logic              last_rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // Next-state decode and timer loading.
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: if (req_valid) begin
                accept = 1'b1;
                if (req_write) begin
                    state_d = last_rd_q ? ST_TURN : ST_WSET;
                end else begin
                    state_d  = ST_RACC;
                    tmr_load = 1'b1;
                    tmr_val  = RD_LD;
                end
            end
            ST_TURN: state_d = ST_WSET;
            ST_WSET: begin
                state_d  = ST_WPUL;
                tmr_load = 1'b1;
                tmr_val  = WP_LD;
            end
            ST_WPUL: if (tmr_expired) begin
                state_d  = ST_WREC;
                tmr_load = 1'b1;
                tmr_val  = WR_LD;
            end
            ST_WREC: if (tmr_expired) state_d = ST_IDLE;
            ST_RACC: if (tmr_expired) begin
                state_d = ST_REND;
                capture = 1'b1;
            end
            ST_REND: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and command latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            last_rd_q <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                last_rd_q <= !req_write;
                addr_q    <= req_addr;
                data_q    <= req_wdata;
            end
        end
    end

    // Registered strobes decoded from the next state, free of glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_ce_n  <= 1'b1;
            ram_oe_n  <= 1'b1;
            ram_we_n  <= 1'b1;
            ram_dq_oe <= 1'b0;
        end else begin
            ram_ce_n  <= !(state_d == ST_WPUL || state_d == ST_RACC);
            ram_oe_n  <= !(state_d == ST_RACC);
            ram_we_n  <= !(state_d == ST_WPUL);
            ram_dq_oe <= (state_d == ST_WSET || state_d == ST_WPUL ||
                          state_d == ST_WREC);
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign ram_addr   = addr_q;
    assign ram_dq_out = data_q;

    // Checker-only counters: consecutive low write-strobe cycles and bus-drive cycles.
    logic [7:0] we_lo_cnt, drv_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_lo_cnt <= '0;
            drv_cnt   <= '0;
        end else begin
            we_lo_cnt <= ram_we_n ? 8'd0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
            drv_cnt   <= !ram_dq_oe ? 8'd0 : ((drv_cnt == 8'hFF) ? drv_cnt : drv_cnt + 8'd1);
        end
    end

    // R1: nothing is strobed while idle
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_ce_n && ram_we_n && ram_oe_n));

    // R6
    oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> (ram_we_n && !ram_dq_oe));

    // R4
    we_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_ce_n && ram_dq_oe));

    // R4
    wpulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (we_lo_cnt >= 8'(WP_CYC)));

    // R5
    whold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (ram_dq_oe && $stable(ram_addr) && $stable(ram_dq_out)));

    // R5
    wcycle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_dq_oe) |-> (drv_cnt >= 8'(WC_CYC)));

    // R8
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_ce_n && $past(!ram_ce_n)) |-> $stable(ram_addr));

endmodule

// File: rtl/sram_bus_ctrl.sv
// Top of the asynchronous RAM controller. Converts nanosecond limits to
// cycle counts and ties the sequencer, phase timer and read register.
// Assumes a free-running clock of CLK_NS and a RAM that needs no refresh.
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int CLK_NS      = 10,
    parameter int T_ADDR_ACC  = 70,
    parameter int T_CE_ACC    = 70,
    parameter int T_OE_ACC    = 35,
    parameter int T_WPULSE    = 55,
    parameter int T_WCYCLE    = 70,
    parameter int T_DSETUP    = 30,
    parameter int T_AHOLD     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_ce_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);

    localparam int RD_CYC   = imax(1, imax(ceil_div(T_ADDR_ACC, CLK_NS),
                                   imax(ceil_div(T_CE_ACC, CLK_NS), ceil_div(T_OE_ACC, CLK_NS))));
    localparam int WP_CYC   = imax(1, imax(ceil_div(T_WPULSE, CLK_NS), ceil_div(T_DSETUP, CLK_NS)));
    localparam int AH_CYC   = imax(1, ceil_div(T_AHOLD, CLK_NS));
    localparam int WC_CYC   = ceil_div(T_WCYCLE, CLK_NS);
    localparam int WREC_CYC = imax(AH_CYC, WC_CYC - 1 - WP_CYC);
    localparam int CNT_W    = $clog2(imax(RD_CYC, imax(WP_CYC, WREC_CYC)) + 1);

    logic             tmr_load, tmr_expired, capture;
    logic [CNT_W-1:0] tmr_val;

    sram_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RD_CYC(RD_CYC),
        .WP_CYC(WP_CYC), .WREC_CYC(WREC_CYC), .WC_CYC(WC_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .capture(capture), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n),
        .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out),
        .ram_dq_oe(ram_dq_oe)
    );

    sram_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expired(tmr_expired)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .capture(capture), .bus_in(ram_dq_in),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

endmodule

// File: tb/sim_sram_bus_ctrl.sv
`timescale 1ns/1ps
module sim_sram_bus_ctrl;

    localparam int CLK_NS  = 10;
    localparam int RD_N    = (70 + CLK_NS - 1) / CLK_NS;
    localparam int WP_N    = (55 + CLK_NS - 1) / CLK_NS;
    localparam int WC_N    = (70 + CLK_NS - 1) / CLK_NS;
    localparam int REC_N   = ((WC_N - 1 - WP_N) > 1) ? (WC_N - 1 - WP_N) : 1;
    localparam int RD_BUSY = RD_N + 1;
    localparam int WR_BUSY = 1 + WP_N + REC_N;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe;
    logic [7:0]  rsp_rdata, ram_dq_out;
    logic [7:0]  ram_dq_in = '0;
    logic [16:0] ram_addr;

    int checks = 0, fails = 0, cycles = 0;

    sram_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
        .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
        .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // ---------------- behavioural RAM with timing monitor ----------------
    logic [7:0]  mem [int];
    int          a_age = 0, ce_age = 0, oe_age = 0, d_age = 0, wr_len = 0, wr_dage = 0;
    logic [16:0] p_addr = '0, wr_addr = '0;
    logic [7:0]  p_dq = '0, wr_data = '0;
    logic        p_wact = 1'b0, p_doe = 1'b0;

    function automatic logic [7:0] ram_rd(input logic [16:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit wact = !ram_ce_n && !ram_we_n;
            automatic bit rd_ok;
            a_age  = (ram_addr != p_addr) ? 1 : a_age + 1;
            ce_age = ram_ce_n ? 0 : ce_age + 1;
            oe_age = ram_oe_n ? 0 : oe_age + 1;
            d_age  = !ram_dq_oe ? 0 : ((p_doe && ram_dq_out == p_dq) ? d_age + 1 : 1);
            if (ram_dq_oe && !ram_oe_n)
                chk(0, "R6 contention oe_n", int'(ram_oe_n), 1);
            if (ce_age > 1 && ram_addr != p_addr)
                chk(0, "R8 address moved under ce_n", int'(ram_addr), int'(p_addr));
            if (wact) begin
                if (!ram_oe_n) chk(0, "R6 oe_n during write", 0, 1);
                wr_len++;
                wr_addr = ram_addr; wr_data = ram_dq_out; wr_dage = d_age;
            end
            if (p_wact && !wact) begin
                chk(wr_len * CLK_NS >= 55, "R4 write pulse ns", wr_len * CLK_NS, 55);
                chk(wr_dage * CLK_NS >= 30, "R4 data setup ns", wr_dage * CLK_NS, 30);
                chk(ram_addr == wr_addr && ram_dq_oe && ram_dq_out == wr_data,
                    "R5 address/data hold", int'(ram_addr), int'(wr_addr));
                chk(a_age * CLK_NS >= 70, "R5 write cycle ns", a_age * CLK_NS, 70);
                mem[int'(wr_addr)] = wr_data;
                wr_len = 0;
            end
            rd_ok = (a_age * CLK_NS >= 70) && (ce_age * CLK_NS >= 70) && (oe_age * CLK_NS >= 35);
            if (!ram_ce_n && ram_we_n && !ram_oe_n)
                ram_dq_in <= rd_ok ? ram_rd(ram_addr) : ~ram_rd(ram_addr);
            else
                ram_dq_in <= 8'h00;
            p_addr = ram_addr; p_dq = ram_dq_out; p_wact = wact; p_doe = ram_dq_oe;
        end
    end

    // ---------------- cycle-by-cycle reference model ----------------
    logic [7:0] ref_mem [int];
    int         exp_busy = 0;
    bit         exp_rd = 0, last_rd = 0;
    logic [7:0] exp_rdata = '0;

    always @(posedge clk) begin
        cycles++;
        if (rst_n) begin
            if (exp_busy > 0) begin
                exp_busy--;
                if (exp_busy == 0) exp_rd = 0;
            end else if (req_valid) begin
                if (req_write) begin
                    exp_busy = last_rd ? WR_BUSY + 1 : WR_BUSY;
                    ref_mem[int'(req_addr)] = req_wdata;
                    last_rd = 0;
                end else begin
                    exp_busy = RD_BUSY;
                    exp_rd = 1;
                    exp_rdata = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 8'h00;
                    last_rd = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            // R2 R3 R5 R7: ready timing compared every cycle
            chk(req_ready == (exp_busy == 0), "R2 R3 R5 R7 req_ready", int'(req_ready), int'(exp_busy == 0));
            chk(rsp_valid == (exp_rd && exp_busy == 1), "R3 rsp_valid", int'(rsp_valid), int'(exp_rd && exp_busy == 1));
            if (rsp_valid && exp_rd && exp_busy == 1)
                chk(rsp_rdata == exp_rdata, "R9 read data", int'(rsp_rdata), int'(exp_rdata));
        end
    end

    task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        repeat (12) @(negedge clk);
        chk(mem.exists(17'h1FFFF) && mem[17'h1FFFF] == 8'h22, "R9 top byte stored", 0, 1);
        chk(ram_rd(17'h00777) == 8'h00, "R2 dropped write left byte", int'(ram_rd(17'h00777)), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready && ram_ce_n && ram_oe_n && ram_we_n && !ram_dq_oe && !rsp_valid,
            "R1 reset outputs", {req_ready, ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe, rsp_valid}, 6'b111100);
        rst_n = 1'b1;
        issue(1, 17'h00000, 8'h11);
        issue(1, 17'h1FFFF, 8'h22);
        issue(1, 17'h0ABCD, 8'h5A);
        issue(1, 17'h00001, 8'hFF);
        issue(1, 17'h00002, 8'h00);
        issue(0, 17'h00000, 8'h00);
        issue(0, 17'h1FFFF, 8'h00);
        issue(0, 17'h0ABCD, 8'h00);
        issue(0, 17'h00001, 8'h00);
        issue(0, 17'h12345, 8'h00);           // never written
        // R7: write right after a read, then read it back
        issue(1, 17'h00002, 8'hC3);
        issue(0, 17'h00002, 8'h00);
        // R2: a request offered while busy is dropped
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00010;
        @(negedge clk);
        req_write = 1'b1; req_addr = 17'h00777; req_wdata = 8'h99;
        @(negedge clk);
        req_valid = 1'b0;
        issue(0, 17'h00777, 8'h00);
        for (int i = 1; i <= 6; i++) begin
            issue(1, 17'((i * 7919) & 17'h1FFFF), 8'(i * 37));
            issue(0, 17'((i * 7919) & 17'h1FFFF), 8'h00);
        end
        finish_run();
    end

    initial begin
        wait (cycles > 20000);
        chk(0, "watchdog expired", cycles, 20000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule